// File: doc/BRIEF.md
# UART Receiver with Per-Character Line Status

This block is the receive half of one serial channel. It oversamples the incoming line at sixteen times the bit rate and turns each character frame into an entry in a receive queue. Every entry carries its own error tags. A start edge is confirmed half a bit later. Each data bit and the parity bit are sampled in the middle of the bit. The block does not make the bit-rate clock: an external enable pulses once per oversample period.

The host takes characters from the head of the queue with a read strobe. A set of status outputs always describes the character waiting at the head: whether one is waiting, whether it had bad parity, whether it lacked a stop bit, and whether it stands for a line break. An overrun indication is separate from the per-character tags. It latches when a character arrives with no room left in the queue, and it clears when the host pulses a status-read strobe. The discarded character never touches the queued data.

A break, meaning the line held low for an entire frame or longer, produces exactly one queue entry however long it lasts. After a break, and after any frame whose stop bit was low, the receiver waits for the line to go high again before it hunts for a new start bit.

Top module: `uart_rx_lsr`

## Requirements
- R1: After reset, every status output is 0 and `rd_data` is 0x00.
- R2: A frame is one low start bit, 8 data bits sent LSB first, one parity bit (even parity by default: the bit makes the total count of ones even) and one high stop bit, each 16 ticks long. Characters come out at `rd_data` in arrival order.
- R3: A low pulse that ends before the mid-point of the start bit (8 ticks) is rejected and queues nothing.
- R4: `st_ready` is 1 while the queue holds at least one character. A `rd_en` pulse removes the head entry. A `rd_en` pulse while the queue is empty changes nothing.
- R5: `st_parity` is 1 exactly when the head character's received parity bit is wrong. It belongs to that character only and follows the head after each read.
- R6: `st_framing` is 1 when the head character was sampled with a low stop bit. After such a frame the receiver waits for the line to return high before it accepts a new start bit.
- R7: A line held low for one frame time or longer yields exactly one entry, with data 0x00 and both `st_break` and `st_framing` set. Only after the line returns high is the next character received normally.
- R8: A character that completes while the queue holds DEPTH entries is dropped. The queued entries and their order are unchanged, and `st_overrun` is 1 from the next cycle.
- R9: `st_overrun` stays set through data reads and clears on a `lsr_rd` pulse. If a new overrun happens in the same cycle as the pulse, the flag stays set.
- R10: While `st_ready` is 0, `st_parity`, `st_framing` and `st_break` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Oversample enable, sixteen per bit period |
| rx | input | 1 | Serial receive line, idle high |
| rd_en | input | 1 | Removes the head character from the queue |
| lsr_rd | input | 1 | Status read strobe; clears the overrun flag |
| rd_data | output | 8 | Head character, 0x00 when the queue is empty |
| st_ready | output | 1 | At least one character is queued |
| st_overrun | output | 1 | A character was dropped because the queue was full (sticky) |
| st_parity | output | 1 | The head character had a parity error |
| st_framing | output | 1 | The head character had a low stop bit |
| st_break | output | 1 | The head character stands for a line break |

## Verification
A wrong sampling phase or bit counter shows up as a wrong `rd_data` value on the first character read after the frame. The full sweep of byte values shows every such fault within one frame. A queue pointer fault shows up as reordered, repeated or lost characters. The fault can hide until the queue wraps or fills, so the overrun case fills the queue to the brim and then drains it. A stuck or misrouted tag appears on `st_parity` or `st_framing` as soon as the affected character reaches the head. A break state that never exits hides every later character, and one that exits too early shows a second break entry.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int RX_DW = 8;

  typedef struct packed {
    logic             brk;
    logic             fe;
    logic             pe;
    logic [RX_DW-1:0] data;
  } rx_entry_t;

  // Parity bit the sender should have produced for this data.
  function automatic logic par_of(input logic [RX_DW-1:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction

  // Pointer distance as an occupancy count (pointers carry one wrap bit).
  function automatic int unsigned occ_of(input int unsigned wp, input int unsigned rp,
                                         input int unsigned span);
    return (wp - rp) % span;
  endfunction
endpackage

// File: rtl/uart_rx_deframer.sv
module uart_rx_deframer
  import uart_rx_pkg::*;
#(
  parameter int OSR        = 16,
  parameter bit PARITY_EN  = 1'b1,
  parameter bit PARITY_ODD = 1'b0
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      rx,
  output logic      char_valid,
  output rx_entry_t char_out,
  output logic      brk_wait
);
  localparam int CW = $clog2(OSR);
  localparam int BW = (RX_DW > 1) ? $clog2(RX_DW) : 1;
  localparam logic [CW-1:0] MID_C  = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] LAST_C = CW'(OSR - 1);
  localparam logic [BW-1:0] TOP_C  = BW'(RX_DW - 1);

  typedef enum logic [2:0] {ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_HOLD} st_t;

  st_t              state;
  logic [1:0]       sync_q;
  logic             rx_s;
  logic [CW-1:0]    cnt;
  logic [BW-1:0]    bit_idx;
  logic [RX_DW-1:0] shreg;
  logic             par_bit;
  logic             all_zero;
  logic             pe_calc;
  logic             is_brk;
  logic             at_last;

  assign rx_s    = sync_q[1];
  assign at_last = (cnt == LAST_C);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], rx};
  end

  generate
    if (PARITY_EN) begin : g_par
      assign pe_calc = (par_bit != par_of(shreg, PARITY_ODD));
    end else begin : g_nopar
      assign pe_calc = 1'b0;
    end
  endgenerate

  always_comb begin
    is_brk        = all_zero && !rx_s;
    char_valid    = tick && (state == ST_STOP) && at_last;
    char_out.brk  = is_brk;
    char_out.fe   = !rx_s;
    char_out.pe   = is_brk ? 1'b0 : pe_calc;
    char_out.data = is_brk ? '0 : shreg;
  end

  assign brk_wait = (state == ST_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      bit_idx  <= '0;
      shreg    <= '0;
      par_bit  <= 1'b0;
      all_zero <= 1'b0;
    end else if (tick) begin
      unique case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (!rx_s) state <= ST_START;
        end
        ST_START: begin
          if (cnt == MID_C) begin
            cnt      <= '0;
            bit_idx  <= '0;
            all_zero <= 1'b1;
            state    <= rx_s ? ST_IDLE : ST_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_DATA: begin
          cnt <= cnt + 1'b1;
          if (at_last) begin
            shreg    <= {rx_s, shreg[RX_DW-1:1]};
            all_zero <= all_zero && !rx_s;
            bit_idx  <= bit_idx + 1'b1;
            if (bit_idx == TOP_C) state <= PARITY_EN ? ST_PAR : ST_STOP;
          end
        end
        ST_PAR: begin
          cnt <= cnt + 1'b1;
          if (at_last) begin
            par_bit  <= rx_s;
            all_zero <= all_zero && !rx_s;
            state    <= ST_STOP;
          end
        end
        ST_STOP: begin
          cnt <= cnt + 1'b1;
          if (at_last) state <= rx_s ? ST_IDLE : ST_HOLD;
        end
        ST_HOLD: begin
          cnt <= '0;
          if (rx_s) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_rx_tag_fifo.sv
module uart_rx_tag_fifo
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      push,
  input  rx_entry_t wdata,
  input  logic      pop,
  output rx_entry_t head,
  output logic      empty,
  output logic      full,
  output logic      ev_push,
  output logic      ev_drop
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  rx_entry_t   mem [DEPTH];
  logic [AW:0] wptr, rptr;
  logic        pop_ok;

  assign empty   = (wptr == rptr);
  assign full    = (wptr[AW] != rptr[AW]) && (wptr[AW-1:0] == rptr[AW-1:0]);
  assign ev_push = push && !full;
  assign ev_drop = push && full;
  assign pop_ok  = pop && !empty;
  assign head    = mem[rptr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (ev_push) mem[wptr[AW-1:0]] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (ev_push) wptr <= wptr + 1'b1;
      if (pop_ok)  rptr <= rptr + 1'b1;
    end
  end
endmodule

// File: rtl/uart_rx_lsr.sv
module uart_rx_lsr
  import uart_rx_pkg::*;
#(
  parameter int DEPTH      = 64,
  parameter int OSR        = 16,
  parameter bit PARITY_EN  = 1'b1,
  parameter bit PARITY_ODD = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick16,
  input  logic             rx,
  input  logic             rd_en,
  input  logic             lsr_rd,
  output logic [RX_DW-1:0] rd_data,
  output logic             st_ready,
  output logic             st_overrun,
  output logic             st_parity,
  output logic             st_framing,
  output logic             st_break
);
  rx_entry_t new_char, head;
  logic      char_valid, brk_wait;
  logic      fifo_empty, fifo_full, ev_push, ev_drop;
  logic      ovr_q;

  uart_rx_deframer #(
    .OSR(OSR), .PARITY_EN(PARITY_EN), .PARITY_ODD(PARITY_ODD)
  ) u_defr (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .rx(rx),
    .char_valid(char_valid), .char_out(new_char), .brk_wait(brk_wait)
  );

  uart_rx_tag_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(char_valid), .wdata(new_char),
    .pop(rd_en), .head(head), .empty(fifo_empty), .full(fifo_full),
    .ev_push(ev_push), .ev_drop(ev_drop)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ovr_q <= 1'b0;
    else if (ev_drop) ovr_q <= 1'b1;
    else if (lsr_rd)  ovr_q <= 1'b0;
  end

  assign st_ready   = !fifo_empty;
  assign st_overrun = ovr_q;
  assign st_parity  = st_ready && head.pe;
  assign st_framing = st_ready && head.fe;
  assign st_break   = st_ready && head.brk;
  assign rd_data    = st_ready ? head.data : '0;
endmodule

// File: rtl/uart_rx_lsr_chk.sv
module uart_rx_lsr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_en,
  input logic       lsr_rd,
  input logic [7:0] rd_data,
  input logic       st_ready,
  input logic       st_overrun,
  input logic       st_parity,
  input logic       st_framing,
  input logic       st_break,
  input logic       ev_push,
  input logic       ev_drop,
  input logic       char_valid,
  input logic       brk_wait
);
  // R8
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_drop |=> st_overrun);
  // R8
  drop_keeps_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_drop && !rd_en |=> $stable(rd_data) && st_ready);
  // R9
  ovr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_overrun && !lsr_rd |=> st_overrun);
  // R9
  ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lsr_rd && !ev_drop |=> !st_overrun);
  // R10
  idle_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !st_ready |-> !(st_parity || st_framing || st_break));
  // R7
  brk_tags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_break |-> st_framing && (rd_data == 8'h00));
  // R7
  one_brk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_wait |-> !char_valid);
  // R4
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !st_ready && !ev_push |=> !st_ready);
endmodule

bind uart_rx_lsr uart_rx_lsr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .lsr_rd(lsr_rd), .rd_data(rd_data),
  .st_ready(st_ready), .st_overrun(st_overrun), .st_parity(st_parity),
  .st_framing(st_framing), .st_break(st_break), .ev_push(ev_push),
  .ev_drop(ev_drop), .char_valid(char_valid), .brk_wait(brk_wait)
);

// File: tb/sim_uart_rx_lsr.sv
module sim_uart_rx_lsr;
  localparam int CLK_P = 10;
  localparam int DEPTH = 4;
  localparam int BITC  = 16;

  logic clk = 1'b0, rst_n = 1'b0, tick16 = 1'b0, rx = 1'b1, rd_en = 1'b0, lsr_rd = 1'b0;
  logic [7:0] rd_data;
  logic st_ready, st_overrun, st_parity, st_framing, st_break;
  int nchk = 0, nerr = 0;

  uart_rx_lsr #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx(rx), .rd_en(rd_en), .lsr_rd(lsr_rd),
    .rd_data(rd_data), .st_ready(st_ready), .st_overrun(st_overrun),
    .st_parity(st_parity), .st_framing(st_framing), .st_break(st_break)
  );

  always #(CLK_P / 2) clk = ~clk;

  task automatic expect_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic even_bit(input logic [7:0] d);
    int ones = 0;
    for (int i = 0; i < 8; i++) ones += d[i];
    return (ones % 2) == 1;
  endfunction

  task automatic hold(input logic v, input int n);
    rx = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic bad_par, input logic bad_stop);
    hold(1'b0, BITC);
    for (int i = 0; i < 8; i++) hold(d[i], BITC);
    hold(even_bit(d) ^ bad_par, BITC);
    hold(!bad_stop, BITC);
    hold(1'b1, 2 * BITC);
  endtask

  task automatic pop();
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic status_read();
    lsr_rd = 1'b1;
    @(negedge clk);
    lsr_rd = 1'b0;
  endtask

  task automatic expect_head(input string req, input logic [7:0] d, input logic pe,
                             input logic fe, input logic bk);
    expect_eq({req, " ready"}, st_ready, 1);
    expect_eq({req, " data"}, rd_data, d);
    expect_eq({req, " parity"}, st_parity, pe);
    expect_eq({req, " framing"}, st_framing, fe);
    expect_eq({req, " break"}, st_break, bk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    expect_eq("R1 ready", st_ready, 0);
    expect_eq("R1 overrun", st_overrun, 0);
    expect_eq("R1 flags", {st_parity, st_framing, st_break}, 0);
    expect_eq("R1 data", rd_data, 0);
    rst_n = 1'b1;
    tick16 = 1'b1;
    repeat (4) @(negedge clk);

    // R4: read strobe on an empty queue
    pop();
    expect_eq("R4 empty read ready", st_ready, 0);
    expect_eq("R4 empty read data", rd_data, 0);

    // R2, R5, R6, R10: sweep every byte value with injected errors
    for (int b = 0; b < 256; b++) begin
      logic bp, bs;
      bp = (b % 5) == 3;
      bs = (b % 7) == 4;
      send(8'(b), bp, bs);
      expect_head("R2/R5/R6 sweep", 8'(b), bp, bs, 1'b0);
      pop();
      expect_eq("R4 drained", st_ready, 0);
      expect_eq("R10 idle flags", {st_parity, st_framing, st_break}, 0);
    end

    // R3: short low glitch is not a start bit
    hold(1'b0, 5);
    hold(1'b1, 3 * BITC);
    expect_eq("R3 glitch rejected", st_ready, 0);

    // R8, R9: fill the queue, then overrun
    send(8'hA0, 1'b0, 1'b0);
    send(8'hA1, 1'b1, 1'b0);
    send(8'hA2, 1'b0, 1'b1);
    send(8'hA3, 1'b0, 1'b0);
    expect_eq("R8 no overrun at full", st_overrun, 0);
    send(8'h5A, 1'b0, 1'b0);
    expect_eq("R8 overrun set", st_overrun, 1);
    expect_head("R8 head intact", 8'hA0, 1'b0, 1'b0, 1'b0);
    pop();
    expect_eq("R9 sticky over read", st_overrun, 1);
    expect_head("R5 tag follows head", 8'hA1, 1'b1, 1'b0, 1'b0);
    status_read();
    expect_eq("R9 cleared by status read", st_overrun, 0);
    pop();
    expect_head("R6 tag follows head", 8'hA2, 1'b0, 1'b1, 1'b0);
    pop();
    expect_head("R8 order kept", 8'hA3, 1'b0, 1'b0, 1'b0);
    pop();
    expect_eq("R8 dropped char absent", st_ready, 0);

    // R7: long break gives one entry, then normal reception resumes
    hold(1'b0, 3 * 11 * BITC);
    hold(1'b1, 2 * BITC);
    send(8'h3C, 1'b0, 1'b0);
    expect_head("R7 break entry", 8'h00, 1'b0, 1'b1, 1'b1);
    pop();
    expect_head("R7 next char", 8'h3C, 1'b0, 1'b0, 1'b0);
    pop();
    expect_eq("R7 single break entry", st_ready, 0);

    finish_run();
  end
endmodule